// File: doc/BRIEF.md
# Radix Page Table Walker

This block translates a 64-bit effective address into a real address by descending a radix tree kept in memory. A request carries the effective address, the access kind (load, store or instruction fetch) and the instruction and data translation enables. When translation is off for that kind of access, the block returns the address unchanged except for its four top bits, which it clears. When translation is on, the two top address bits select a quadrant, and the quadrant decides which process identifier indexes the process table. The block reads one doubleword of that table entry, which gives the tree root, and then reads one 8-byte entry per level until it finds a leaf, an invalid entry or an impossible level size.

The result goes out on a single-cycle completion pulse. On success it carries the real address, the leaf entry, the leaf entry's address and the page-size exponent reached. On failure it carries a fault cause code. Memory is reached through a valid/ready read request and a 64-bit response. Only one read is in flight at a time, and only one walk runs at a time.

Top module: `radix_walker`

## Requirements
- R1: If translation is off for the access kind (`req_ir` governs fetches, `req_dr` governs loads and stores), the walk completes with no memory read and no fault, with `done_raddr` = EA with bits 63:60 cleared and `done_psize` = 0.
- R2: With translation on, EA[63:62] equal to 1 or 2 completes with no memory read, with cause 1 (instruction segment fault) for fetches and cause 2 (data segment fault) for loads and stores. Kind codes: 0 load, 1 store, 2 fetch.
- R3: Quadrant 0 (EA[63:62]=0) indexes the process table with `pid_reg`. Quadrant 3 uses PID 0. The table doubleword is read at {ptab_base[63:12], 12'b0} + PID*16.
- R4: If PID*16 >= 2^(ptab_exp+12), the walk completes with cause 3 (no entry) and no memory read.
- R5: The table doubleword supplies the root base as {bits[55:8], 8'b0}, the entry-count exponent nls in bits[4:0] and the starting page-size exponent psize in bits[61:56]. Each level reads the entry at base + ((EA' >> (psize-nls)) & (2^nls-1))*8, with EA' = EA with bits 63:62 cleared, and then psize becomes psize-nls.
- R6: A level whose nls is below 5 or above the current psize ends the walk with cause 4 (bad configuration) before any read for that level.
- R7: A fetched entry with bit 63 (valid) clear ends the walk with cause 3 (no entry).
- R8: A valid entry with bit 62 (leaf) set ends the walk with no fault. `done_raddr` = (entry & bits 55:12 & ~M) | (EA' & M), with M = 2^psize-1 for the reduced psize. `done_pte` is the entry, `done_pte_addr` its address and `done_psize` that psize.
- R9: A valid non-leaf entry continues the walk with base {bits[55:8], 8'b0} and nls from bits[4:0].
- R10: A memory request holds its address stable until accepted. No request is raised while a response is awaited or while idle. Every request address is 8-byte aligned.
- R11: After reset, `req_ready`=1, `done`=0 and `mem_req_valid`=0. `done` lasts exactly one cycle, and the block is ready again in that cycle. `done_fault` is 1 exactly when the cause is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle and accepting |
| req_ea | input | 64 | Effective address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_ir | input | 1 | Instruction translation enable |
| req_dr | input | 1 | Data translation enable |
| pid_reg | input | PID_W | Process identifier for quadrant 0 |
| ptab_base | input | 64 | Process table base (bits 63:12 used) |
| ptab_exp | input | TEXP_W | Table size exponent, size = 2^(exp+12) bytes |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 64 | Read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| done | output | 1 | Completion pulse |
| done_fault | output | 1 | Walk ended in a fault |
| done_cause | output | 3 | Fault cause code |
| done_raddr | output | 64 | Real address |
| done_pte | output | 64 | Leaf entry |
| done_pte_addr | output | 64 | Leaf entry address |
| done_psize | output | 7 | Page-size exponent reached |

## Verification
The bench builds the walker with PID_W=10 and a 4 KiB process table (ptab_exp=0). This puts PIDs on both sides of the table-size limit (256 entries) within reach of the pid input. A three-level tree with 32-, 32- and 64-entry directories fits in an 8 KiB model memory, and the bench sweeps every root and second-level index plus three third-level indices. That sweep reaches leaves at every depth, invalid entries, and both bad-size cases: an exponent below 5, and an exponent larger than the remaining page size. The memory model varies its acceptance and latency so that requests stall and responses arrive late. Quadrant, kind and enable combinations cover bypass, segment faults and the PID choice.

// File: rtl/rwalk_pkg.sv
package rwalk_pkg;
    localparam int ADDR_W   = 64;
    localparam int NLS_W    = 5;
    localparam int PSZ_W    = 7;
    localparam int VLD_BIT  = 63;
    localparam int LEAF_BIT = 62;
    localparam int BASE_HI  = 55;
    localparam int BASE_LO  = 8;
    localparam int RPN_HI   = 55;
    localparam int RPN_LO   = 12;
    localparam int PSF_HI   = 61;
    localparam int PSF_LO   = 56;
    localparam int MIN_NLS  = 5;
    localparam int TAB_SH   = 12;
    localparam int PTE_SZ_SH = 4;

    typedef enum logic [2:0] {
        CZ_NONE     = 3'd0,
        CZ_SEG_INSN = 3'd1,
        CZ_SEG_DATA = 3'd2,
        CZ_NO_ENTRY = 3'd3,
        CZ_BAD_CFG  = 3'd4
    } cause_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_TAB_REQ = 3'd1,
        ST_TAB_RSP = 3'd2,
        ST_DIR_REQ = 3'd3,
        ST_DIR_RSP = 3'd4
    } wstate_e;

    typedef struct packed {
        wstate_e             st;
        logic [ADDR_W-1:0]   ea;
        logic [ADDR_W-1:0]   base;
        logic [NLS_W-1:0]    nls;
        logic [PSZ_W-1:0]    psize;
        logic [ADDR_W-1:0]   tab_addr;
        logic                done;
        cause_e              cause;
        logic [ADDR_W-1:0]   raddr;
        logic [ADDR_W-1:0]   pte;
        logic [ADDR_W-1:0]   pte_addr;
    } wregs_t;
endpackage

// File: rtl/rw_route.sv
module rw_route
    import rwalk_pkg::*;
#(
    parameter int PID_W  = 16,
    parameter int TEXP_W = 5
) (
    input  logic [ADDR_W-1:0] ea,
    input  acc_e              kind,
    input  logic              ir_on,
    input  logic              dr_on,
    input  logic [PID_W-1:0]  pid_reg,
    input  logic [TEXP_W-1:0] tab_exp,
    output logic              bypass,
    output logic              seg_fault,
    output cause_e            seg_cause,
    output logic              pid_oob,
    output logic [PID_W-1:0]  pid_sel
);
    logic              xlat_on;
    logic [1:0]        quad;
    logic [ADDR_W-1:0] pid_off;
    logic [ADDR_W-1:0] tab_bytes;
    logic [PSZ_W-1:0]  tab_sh;

    always_comb begin
        xlat_on   = (kind == ACC_FETCH) ? ir_on : dr_on;
        bypass    = !xlat_on;
        quad      = ea[ADDR_W-1:ADDR_W-2];
        seg_fault = xlat_on && ((quad == 2'd1) || (quad == 2'd2));
        seg_cause = (kind == ACC_FETCH) ? CZ_SEG_INSN : CZ_SEG_DATA;
        pid_sel   = (quad == 2'd0) ? pid_reg : '0;
        pid_off   = ADDR_W'(pid_sel) << PTE_SZ_SH;
        tab_sh    = PSZ_W'(tab_exp) + PSZ_W'(TAB_SH);
        tab_bytes = {{(ADDR_W-1){1'b0}}, 1'b1} << tab_sh;
        pid_oob   = (pid_off >= tab_bytes);
    end
endmodule

// File: rtl/rw_level.sv
module rw_level
    import rwalk_pkg::*;
(
    input  logic [ADDR_W-1:0] ea_m,
    input  logic [ADDR_W-1:0] base,
    input  logic [NLS_W-1:0]  nls,
    input  logic [PSZ_W-1:0]  psize,
    output logic [ADDR_W-1:0] ent_addr,
    output logic              bad_cfg,
    output logic [PSZ_W-1:0]  psize_next
);
    logic [PSZ_W-1:0]  nls_w;
    logic [ADDR_W-1:0] idx_mask;
    logic [ADDR_W-1:0] idx;

    always_comb begin
        nls_w      = PSZ_W'(nls);
        bad_cfg    = (nls < NLS_W'(MIN_NLS)) || (nls_w > psize);
        psize_next = psize - nls_w;
        idx_mask   = ({{(ADDR_W-1){1'b0}}, 1'b1} << nls) - ADDR_W'(1);
        idx        = (ea_m >> psize_next) & idx_mask;
        ent_addr   = base + (idx << 3);
    end
endmodule

// File: rtl/rw_leaf.sv
module rw_leaf
    import rwalk_pkg::*;
(
    input  logic [ADDR_W-1:0] ea_m,
    input  logic [ADDR_W-1:0] entry,
    input  logic [PSZ_W-1:0]  psize,
    output logic [ADDR_W-1:0] raddr
);
    localparam logic [ADDR_W-1:0] RPN_MASK =
        ({{(ADDR_W-1){1'b0}}, 1'b1} << (RPN_HI + 1)) - ({{(ADDR_W-1){1'b0}}, 1'b1} << RPN_LO);

    logic [ADDR_W-1:0] pmask;

    always_comb begin
        pmask = ({{(ADDR_W-1){1'b0}}, 1'b1} << psize) - ADDR_W'(1);
        raddr = (entry & RPN_MASK & ~pmask) | (ea_m & pmask);
    end
endmodule

// File: rtl/radix_walker.sv
module radix_walker
    import rwalk_pkg::*;
#(
    parameter int PID_W  = 16,
    parameter int TEXP_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [63:0]       req_ea,
    input  logic [1:0]        req_kind,
    input  logic              req_ir,
    input  logic              req_dr,
    input  logic [PID_W-1:0]  pid_reg,
    input  logic [63:0]       ptab_base,
    input  logic [TEXP_W-1:0] ptab_exp,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [63:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data,
    output logic              done,
    output logic              done_fault,
    output logic [2:0]        done_cause,
    output logic [63:0]       done_raddr,
    output logic [63:0]       done_pte,
    output logic [63:0]       done_pte_addr,
    output logic [6:0]        done_psize
);
    wregs_t q, d;

    logic              rt_bypass;
    logic              rt_seg;
    cause_e            rt_seg_cause;
    logic              rt_oob;
    logic [PID_W-1:0]  rt_pid;
    logic [ADDR_W-1:0] lv_addr;
    logic              lv_bad;
    logic [PSZ_W-1:0]  lv_psize;
    logic [ADDR_W-1:0] lf_raddr;
    logic [ADDR_W-1:0] tab_root;

    rw_route #(.PID_W(PID_W), .TEXP_W(TEXP_W)) u_route (
        .ea        (req_ea),
        .kind      (acc_e'(req_kind)),
        .ir_on     (req_ir),
        .dr_on     (req_dr),
        .pid_reg   (pid_reg),
        .tab_exp   (ptab_exp),
        .bypass    (rt_bypass),
        .seg_fault (rt_seg),
        .seg_cause (rt_seg_cause),
        .pid_oob   (rt_oob),
        .pid_sel   (rt_pid)
    );

    rw_level u_level (
        .ea_m       (q.ea),
        .base       (q.base),
        .nls        (q.nls),
        .psize      (q.psize),
        .ent_addr   (lv_addr),
        .bad_cfg    (lv_bad),
        .psize_next (lv_psize)
    );

    rw_leaf u_leaf (
        .ea_m  (q.ea),
        .entry (mem_rsp_data),
        .psize (q.psize),
        .raddr (lf_raddr)
    );

    assign tab_root = {ptab_base[ADDR_W-1:TAB_SH], {TAB_SH{1'b0}}};

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.ea       = {2'b00, req_ea[ADDR_W-3:0]};
                    d.raddr    = '0;
                    d.pte      = '0;
                    d.pte_addr = '0;
                    d.psize    = '0;
                    d.cause    = CZ_NONE;
                    if (rt_bypass) begin
                        d.done  = 1'b1;
                        d.raddr = {4'b0000, req_ea[ADDR_W-5:0]};
                    end else if (rt_seg) begin
                        d.done  = 1'b1;
                        d.cause = rt_seg_cause;
                    end else if (rt_oob) begin
                        d.done  = 1'b1;
                        d.cause = CZ_NO_ENTRY;
                    end else begin
                        d.tab_addr = tab_root + (ADDR_W'(rt_pid) << PTE_SZ_SH);
                        d.st       = ST_TAB_REQ;
                    end
                end
            end
            ST_TAB_REQ: begin
                if (mem_req_ready) d.st = ST_TAB_RSP;
            end
            ST_TAB_RSP: begin
                if (mem_rsp_valid) begin
                    d.base  = {mem_rsp_data[BASE_HI:BASE_LO], {BASE_LO{1'b0}}} & {{(ADDR_W-BASE_HI-1){1'b0}}, {(BASE_HI+1){1'b1}}};
                    d.nls   = mem_rsp_data[NLS_W-1:0];
                    d.psize = PSZ_W'(mem_rsp_data[PSF_HI:PSF_LO]);
                    d.st    = ST_DIR_REQ;
                end
            end
            ST_DIR_REQ: begin
                if (lv_bad) begin
                    d.done  = 1'b1;
                    d.cause = CZ_BAD_CFG;
                    d.st    = ST_IDLE;
                end else if (mem_req_ready) begin
                    d.pte_addr = lv_addr;
                    d.psize    = lv_psize;
                    d.st       = ST_DIR_RSP;
                end
            end
            ST_DIR_RSP: begin
                if (mem_rsp_valid) begin
                    if (!mem_rsp_data[VLD_BIT]) begin
                        d.done  = 1'b1;
                        d.cause = CZ_NO_ENTRY;
                        d.st    = ST_IDLE;
                    end else if (mem_rsp_data[LEAF_BIT]) begin
                        d.done  = 1'b1;
                        d.raddr = lf_raddr;
                        d.pte   = mem_rsp_data;
                        d.st    = ST_IDLE;
                    end else begin
                        d.base = {{(ADDR_W-BASE_HI-1){1'b0}}, mem_rsp_data[BASE_HI:BASE_LO], {BASE_LO{1'b0}}};
                        d.nls  = mem_rsp_data[NLS_W-1:0];
                        d.st   = ST_DIR_REQ;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready     = (q.st == ST_IDLE);
    assign mem_req_valid = (q.st == ST_TAB_REQ) || ((q.st == ST_DIR_REQ) && !lv_bad);
    assign mem_req_addr  = (q.st == ST_TAB_REQ) ? q.tab_addr : lv_addr;
    assign done          = q.done;
    assign done_cause    = q.cause;
    assign done_fault    = (q.cause != CZ_NONE);
    assign done_raddr    = q.raddr;
    assign done_pte      = q.pte;
    assign done_pte_addr = q.pte_addr;
    assign done_psize    = q.psize;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R10
    AST_REQ_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000)); // R10
    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid); // R10
    AST_NO_REQ_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> !mem_req_valid); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready); // R11
    AST_PSIZE_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DIR_REQ) && mem_req_valid && mem_req_ready |=> q.psize < $past(q.psize)); // R5
endmodule

// File: tb/sim_radix_walker.sv
module sim_radix_walker;
    localparam int CLK_PERIOD = 10;
    localparam int PIDW = 10;
    localparam logic [63:0] V = 64'h8000_0000_0000_0000;
    localparam logic [63:0] L = 64'h4000_0000_0000_0000;
    localparam logic [63:0] RPNM = 64'h00FF_FFFF_FFFF_F000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [63:0] req_ea = '0;
    logic [1:0] req_kind = '0;
    logic req_ir = 1'b1;
    logic req_dr = 1'b1;
    logic [PIDW-1:0] pid_reg = '0;
    logic [63:0] ptab_base = 64'h0;
    logic [4:0] ptab_exp = 5'd0;
    logic mem_req_valid;
    logic mem_req_ready;
    logic [63:0] mem_req_addr;
    logic mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic done, done_fault;
    logic [2:0] done_cause;
    logic [63:0] done_raddr, done_pte, done_pte_addr;
    logic [6:0] done_psize;

    int errors = 0;
    int checks = 0;
    int mem_reads = 0;

    logic [63:0] mem [0:1023];
    logic busy = 1'b0;
    logic [1:0] lat = '0;
    logic [63:0] addr_q = '0;
    logic [7:0] tick = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    radix_walker #(.PID_W(PIDW), .TEXP_W(5)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea),
        .req_kind(req_kind), .req_ir(req_ir), .req_dr(req_dr),
        .pid_reg(pid_reg), .ptab_base(ptab_base), .ptab_exp(ptab_exp),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .done(done), .done_fault(done_fault), .done_cause(done_cause),
        .done_raddr(done_raddr), .done_pte(done_pte),
        .done_pte_addr(done_pte_addr), .done_psize(done_psize)
    );

    function automatic logic [63:0] rd(input logic [63:0] a);
        if (a < 64'h2000) return mem[a[12:3]];
        return 64'h0;
    endfunction

    assign mem_req_ready = !busy && (tick[2:0] != 3'd3);

    always @(posedge clk) begin
        tick <= tick + 8'd1;
        mem_rsp_valid <= 1'b0;
        if (busy) begin
            if (lat == 2'd0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= rd(addr_q);
                busy <= 1'b0;
            end else begin
                lat <= lat - 2'd1;
            end
        end else if (rst_n && mem_req_valid && mem_req_ready) begin
            busy <= 1'b1;
            addr_q <= mem_req_addr;
            lat <= tick[4:3];
            mem_reads <= mem_reads + 1;
        end
    end

    // Reference computed from the requirements.
    task automatic ref_walk(input logic [63:0] ea, input logic [1:0] kind,
                            input logic ir, input logic dr, input logic [PIDW-1:0] pidr,
                            output logic [2:0] c, output logic [63:0] ra,
                            output logic [63:0] pte, output logic [63:0] pa,
                            output int ps);
        logic [63:0] e, base, em, idx, m;
        int nls, lvl;
        logic [1:0] qd;
        logic [63:0] pid;
        c = 3'd0; ra = '0; pte = '0; pa = '0; ps = 0;
        if (!((kind == 2'd2) ? ir : dr)) begin
            ra = ea & 64'h0FFF_FFFF_FFFF_FFFF;
            return;
        end
        qd = ea[63:62];
        if (qd == 2'd1 || qd == 2'd2) begin
            c = (kind == 2'd2) ? 3'd1 : 3'd2;
            return;
        end
        pid = (qd == 2'd0) ? 64'(pidr) : 64'd0;
        if (pid * 16 >= (64'd1 << (ptab_exp + 12))) begin
            c = 3'd3;
            return;
        end
        e = rd({ptab_base[63:12], 12'h0} + pid * 16);
        base = e & 64'h00FF_FFFF_FFFF_FF00;
        nls = int'(e[4:0]);
        ps = int'(e[61:56]);
        em = ea & 64'h3FFF_FFFF_FFFF_FFFF;
        for (lvl = 0; lvl < 16; lvl++) begin
            if (nls < 5 || nls > ps) begin
                c = 3'd4;
                return;
            end
            ps = ps - nls;
            idx = (em >> ps) & ((64'd1 << nls) - 1);
            pa = base + idx * 8;
            e = rd(pa);
            if (!e[63]) begin
                c = 3'd3;
                return;
            end
            if (e[62]) begin
                m = (64'd1 << ps) - 1;
                ra = (e & RPNM & ~m) | (em & m);
                pte = e;
                return;
            end
            base = e & 64'h00FF_FFFF_FFFF_FF00;
            nls = int'(e[4:0]);
        end
    endtask

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic walk(input logic [63:0] ea, input logic [1:0] kind, input logic ir,
                        input logic dr, input string tag);
        logic [2:0] ec;
        logic [63:0] era, epte, epa;
        int eps, r0, cyc;
        ref_walk(ea, kind, ir, dr, pid_reg, ec, era, epte, epa, eps);
        @(negedge clk);
        req_valid = 1'b1; req_ea = ea; req_kind = kind; req_ir = ir; req_dr = dr;
        r0 = mem_reads;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            chk(1'b0, {tag, " timeout"}, 64'(cyc), 64'd200);
            return;
        end
        chk(done_cause == ec, {tag, " cause"}, 64'(done_cause), 64'(ec));
        chk(done_fault == (ec != 3'd0), "R11 fault flag", 64'(done_fault), 64'(ec != 3'd0));
        if (ec == 3'd0) begin
            chk(done_raddr == era, {tag, " raddr"}, done_raddr, era);
            chk(done_psize == 7'(eps), {tag, " psize"}, 64'(done_psize), 64'(eps));
            if (eps != 0) begin
                chk(done_pte == epte, "R8 pte", done_pte, epte);
                chk(done_pte_addr == epa, "R5 pte addr", done_pte_addr, epa);
            end else begin
                chk(mem_reads == r0, "R1 no read", 64'(mem_reads - r0), 64'd0);
            end
        end else if (ec != 3'd4 && ec != 3'd3 || (ec == 3'd3 && epa == 0 && era == 0 && epte == 0 && tag == "R4")) begin
            chk(mem_reads == r0, {tag, " no read"}, 64'(mem_reads - r0), 64'd0);
        end
        @(negedge clk);
        chk(!done, "R11 pulse", 64'(done), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R11 actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int a = 0; a < 1024; a++) mem[a] = '0;
        mem[0] = (64'd20 << 56) | 64'h1000 | 64'd5;  // PID 0
        mem[2] = (64'd20 << 56) | 64'h1000 | 64'd4;  // PID 1: root exponent too small
        for (int i = 0; i < 32; i++) begin
            case (i % 4)
                0: mem[(32'h1000 >> 3) + i] = 64'h0;
                1: mem[(32'h1000 >> 3) + i] = V | L | (64'(i) << 24) | 64'h00C0_0000_0000 | 64'hFFF000;
                2: mem[(32'h1000 >> 3) + i] = V | 64'h1100 | 64'd5;
                default: mem[(32'h1000 >> 3) + i] = V | 64'h1100 | 64'd3;
            endcase
            case (i % 3)
                0: mem[(32'h1100 >> 3) + i] = 64'h0;
                1: mem[(32'h1100 >> 3) + i] = V | L | (64'(i) << 30) | 64'h3F000;
                default: mem[(32'h1100 >> 3) + i] = V | 64'h1200 | 64'd6;
            endcase
        end
        for (int k = 0; k < 64; k++)
            mem[(32'h1200 >> 3) + k] = (k == 63) ? (V | 64'h1000 | 64'd5)
                                                  : (V | L | (64'(k) << 36) | 64'hABCDE000);
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R11 reset ready", 64'(req_ready), 64'd1);
        chk(done == 1'b0, "R11 reset done", 64'(done), 64'd0);
        chk(mem_req_valid == 1'b0, "R11 reset memreq", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;

        walk(64'hF234_5678_9ABC_DEF0, 2'd2, 1'b0, 1'b1, "R1");
        walk(64'h7FFF_0000_1234_5678, 2'd0, 1'b1, 1'b0, "R1");
        walk(64'h4000_0000_0000_1000, 2'd1, 1'b1, 1'b0, "R1");
        walk(64'h4000_0000_0000_1000, 2'd2, 1'b1, 1'b1, "R2");
        walk(64'h8000_0000_0000_1000, 2'd0, 1'b1, 1'b1, "R2");
        walk(64'h8000_0000_0000_1000, 2'd1, 1'b0, 1'b1, "R2");
        walk(64'h4000_0000_0000_0000, 2'd2, 1'b1, 1'b0, "R2");

        pid_reg = 10'd1;
        walk(64'h0000_0000_0000_8000, 2'd0, 1'b1, 1'b1, "R3/R6");
        walk(64'hC000_0000_0000_8000, 2'd0, 1'b1, 1'b1, "R3");
        pid_reg = 10'd300;
        walk(64'h0000_0000_0000_8000, 2'd1, 1'b1, 1'b1, "R4");
        walk(64'hC000_0000_0001_0000, 2'd2, 1'b1, 1'b1, "R3");
        pid_reg = 10'd255;
        walk(64'h0000_0000_0000_8000, 2'd0, 1'b1, 1'b1, "R4");
        pid_reg = 10'd256;
        walk(64'h0000_0000_0000_8000, 2'd0, 1'b1, 1'b1, "R4");

        pid_reg = 10'd0;
        for (int i = 0; i < 32; i++)
            for (int j = 0; j < 32; j++)
                for (int s = 0; s < 3; s++) begin
                    automatic int k = (s == 0) ? 0 : ((s == 1) ? 17 : 63);
                    automatic logic [63:0] ea = (64'(i) << 15) | (64'(j) << 10) |
                                                (64'(k) << 4) | 64'h9 | (64'(i & 1) << 40);
                    walk(ea, 2'(s), 1'b1, 1'b1, "R5/R6/R7/R8/R9");
                end
        for (int i = 0; i < 32; i++)
            walk((64'h3 << 62) | (64'(i) << 15) | (64'd14 << 10) | 64'h3A5, 2'd0, 1'b1, 1'b1, "R3");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule